// File: doc/BRIEF.md
# CD Decoder Host Register Port

This block is the host-facing register window of a CD data decoder controller. The host first selects a register by loading a 4-bit index. It then reads or writes one byte at a time through a single data port. Reads and writes reach two different register maps that share one index. After most accesses the index steps forward by one, so the host can sweep a group of registers without reloading the index. Certain writes have side effects: they stop or start a data transfer, acknowledge the transfer-end interrupt, or return the block to its reset contents.

The block publishes its registers to the rest of the controller as parallel outputs. These are the byte count, data address, write address, pointer, control bytes, header, status word and transfer flags. The decoder engine and the transfer engine reach the block through a few inputs: a status-word load, clear masks for interface status bits, and a transfer-end pulse. The block keeps a record of which decode registers the host has read. When the host reads the last status byte and that record is complete, the block raises the ready bit of that byte again. Sector decoding itself is outside this block.

Top module: `cdc_regport`

## Requirements
- R1: After rst_n is held low on a clock edge, the block holds these values: if_stat 0xFF, write_addr 0x1260 (4704), stat_word 0x00000080, xfer_active 0, xfer_end 0, index 0, rdata 0. Every other register and the read-tracking record hold zero.
- R2: A read returns, one cycle later, the register at the current index. The read map is: 0 cmd_in, 1 if_stat, 2/3 byte_cnt low/high, 4..7 header bytes 0..3, 8/9 pointer low/high, 0xA/0xB write_addr low/high, 0xC..0xF stat_word bytes 0..3. A read advances the index by one, except a read at index 0xF, which leaves the index unchanged.
- R3: A write stores wdata at the current index. The write map is: 0 sub_out, 1 if_ctrl, 2/3 byte_cnt low/high, 4/5 data_addr low/high, 6 transfer trigger, 7 transfer acknowledge, 8/9 write_addr low/high, 0xA ctrl0, 0xB ctrl1, 0xC/0xD pointer low/high, 0xE ctrl2, 0xF soft reset. A write at index 6, 7, 0xE or 0xF leaves the index unchanged. Any other write advances it by one.
- R4: Header byte 0 (bits 7:0) holds the BCD minute, byte 1 the BCD second, byte 2 the BCD frame, and byte 3 the value 0x01. This applies while ctrl1 bit 0 is clear and the position inputs are below 100. While ctrl1 bit 0 is set, all four header bytes read 0.
- R5: A write to if_ctrl with wdata bit 1 clear zeroes byte_cnt, clears xfer_active and sets if_stat bit 3.
- R6: A trigger write while if_ctrl bit 1 is set does three things: it clears if_stat bit 3, sets xfer_active, and clears xfer_end. While if_ctrl bit 1 is clear, a trigger write changes none of these. An end_set pulse sets xfer_end.
- R7: An acknowledge write sets if_stat bit 6.
- R8: A read at index 0xF returns the old status byte 3 and sets if_stat bit 5.
- R9: The read-tracking record gains bit k when index k is read, for k in 1, 4..9 and 0xC..0xE. Consider a read at index 0xF made while ctrl0 bit 7 and if_ctrl bit 5 are both set. If the record then covers mask 0x73F2, status byte 3 becomes 0x80 after that read. Otherwise status byte 3 is unchanged.
- R10: A soft-reset write restores every R1 value except the index, rdata and xfer_end, and it also clears the tracking record.
- R11: idx_ld loads idx_din into the index, and any read or write strobe in the same cycle is ignored. When rd_stb and wr_stb are both high, only the write takes place.
- R12: rdata changes only on a performed read. On every other cycle it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_ld | input | 1 | Load register index |
| idx_din | input | 4 | Index value to load |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| idx | output | 4 | Current register index |
| cmd_in | input | 8 | Command-in byte from the controller |
| pos_min | input | 7 | Current minute, binary |
| pos_sec | input | 7 | Current second, binary |
| pos_frm | input | 7 | Current frame, binary |
| stat_ld | input | 1 | Load stat_in into the status word |
| stat_in | input | 32 | Status word from the decoder |
| ifstat_clr | input | 8 | Per-bit clear of if_stat |
| end_set | input | 1 | Transfer-end pulse from the transfer engine |
| sub_out | output | 8 | Sub-output register |
| if_ctrl | output | 8 | Interface control |
| if_stat | output | 8 | Interface status |
| byte_cnt | output | 16 | Transfer byte count |
| data_addr | output | 16 | Transfer data address |
| write_addr | output | 16 | Buffer write address |
| pointer | output | 16 | Block pointer |
| ctrl0 | output | 8 | Control byte 0 |
| ctrl1 | output | 8 | Control byte 1 |
| ctrl2 | output | 8 | Control byte 2 |
| header | output | 32 | Header bytes 0..3 |
| stat_word | output | 32 | Status bytes 0..3 |
| xfer_active | output | 1 | Transfer in progress |
| xfer_end | output | 1 | Transfer ended flag |

## Verification
The assertions assume the following about the inputs. The position inputs stay below 100. stat_ld does not coincide with a read at index 0xF. end_set is not pulsed in the same cycle as a trigger write. Under these assumptions, each side effect is attributed to a single source in each cycle. The stimulus keeps to these rules because it drives only one kind of event per access cycle, with an idle cycle between accesses. Strobe collisions appear only in the dedicated priority cases of R11.

// File: rtl/cdc_regport_pkg.sv
// Package: shared widths, register indices and helpers for the register port.
// Assumes the index is 4 bits wide, so both maps have 16 entries.
package cdc_regport_pkg;
    localparam int IDX_W  = 4;
    localparam int NREG   = 1 << IDX_W;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int QUAD_W = 4 * BYTE_W;
    localparam int POS_W  = 7;

    // write-side index codes whose behaviour is special
    localparam logic [IDX_W-1:0] W_IFCTRL = 4'h1;
    localparam logic [IDX_W-1:0] W_TRIG   = 4'h6;
    localparam logic [IDX_W-1:0] W_ACK    = 4'h7;
    localparam logic [IDX_W-1:0] W_CTRL2  = 4'hE;
    localparam logic [IDX_W-1:0] W_SRST   = 4'hF;
    // read-side index of the last status byte
    localparam logic [IDX_W-1:0] R_STAT3  = 4'hF;

    // binary value (< 100) to packed two-digit BCD
    function automatic logic [BYTE_W-1:0] to_bcd(input logic [POS_W-1:0] v);
        return (BYTE_W'(v / 7'd10) << 4) | BYTE_W'(v % 7'd10);
    endfunction
endpackage

// File: rtl/cdc_hdr_build.sv
// Module: builds the four header bytes from the current disc position.
// Assumes position inputs are below 100; the subheader select zeroes all bytes.
module cdc_hdr_build
    import cdc_regport_pkg::*;
(
    input  logic [POS_W-1:0]  pos_min,
    input  logic [POS_W-1:0]  pos_sec,
    input  logic [POS_W-1:0]  pos_frm,
    input  logic              sub_hdr,
    output logic [QUAD_W-1:0] hdr
);
    localparam logic [BYTE_W-1:0] MODE_BYTE = 8'h01;

    // header bytes: BCD position plus mode, or all zero
    always_comb begin
        if (sub_hdr)
            hdr = '0;
        else
            hdr = {MODE_BYTE, to_bcd(pos_frm), to_bcd(pos_sec), to_bcd(pos_min)};
    end
endmodule

// File: rtl/cdc_idx_ctr.sv
// Module: register index with non-uniform auto-increment.
// Assumes rd/wr inputs are already qualified (write wins, load wins over both).
module cdc_idx_ctr
    import cdc_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [IDX_W-1:0] din,
    input  logic             rd,
    input  logic             wr,
    output logic [IDX_W-1:0] idx
);
    logic wr_holds;
    logic rd_holds;

    // writes to trigger, ack, ctrl2 and soft reset keep the index
    always_comb begin
        wr_holds = (idx == W_TRIG) || (idx == W_ACK) ||
                   (idx == W_CTRL2) || (idx == W_SRST);
        rd_holds = (idx == R_STAT3);
    end

    // index register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (ld)
            idx <= din;
        else if (wr) begin
            if (!wr_holds) idx <= idx + 1'b1;
        end else if (rd) begin
            if (!rd_holds) idx <= idx + 1'b1;
        end
    end

    p_ld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> idx == $past(din));
    p_rd_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !ld && idx != 4'hF) |=> idx == $past(idx) + 4'd1);
    p_rd_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !ld && idx == 4'hF) |=> idx == 4'hF);
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ld && (idx == 4'h6 || idx == 4'h7 || idx == 4'hE || idx == 4'hF))
        |=> $stable(idx));
endmodule

// File: rtl/cdc_xfer_ctl.sv
// Module: interface status byte and transfer flags.
// Assumes strobes are qualified accesses; external clears apply first,
// host side effects then set or clear over them.
module cdc_xfer_ctl
    import cdc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [BYTE_W-1:0] clr_mask,
    input  logic              end_set,
    input  logic              ifc_wr,
    input  logic              ifc_en_bit,
    input  logic              trig_wr,
    input  logic              xfer_en,
    input  logic              ack_wr,
    input  logic              stat3_rd,
    output logic [BYTE_W-1:0] if_stat,
    output logic              active,
    output logic              xfer_end
);
    localparam int B_BUSY_N = 3;
    localparam int B_DEC_N  = 5;
    localparam int B_END_N  = 6;

    logic              start;
    logic              stop;
    logic [BYTE_W-1:0] stat_nx;

    // decode start/stop and form next status byte
    always_comb begin
        start   = trig_wr && xfer_en;
        stop    = ifc_wr && !ifc_en_bit;
        stat_nx = if_stat & ~clr_mask;
        if (stop)     stat_nx[B_BUSY_N] = 1'b1;
        if (start)    stat_nx[B_BUSY_N] = 1'b0;
        if (ack_wr)   stat_nx[B_END_N]  = 1'b1;
        if (stat3_rd) stat_nx[B_DEC_N]  = 1'b1;
    end

    // status byte and active flag registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            if_stat <= '1;
            active  <= 1'b0;
        end else begin
            if_stat <= stat_nx;
            if (start)     active <= 1'b1;
            else if (stop) active <= 1'b0;
        end
    end

    // transfer-end flag: cleared by a start, set by the engine
    always_ff @(posedge clk) begin
        if (!rst_n)       xfer_end <= 1'b0;
        else if (start)   xfer_end <= 1'b0;
        else if (end_set) xfer_end <= 1'b1;
    end

    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ifc_wr && !ifc_en_bit && !soft_rst) |=> (!active && if_stat[3]));
    p_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && xfer_en && !soft_rst) |=> (active && !if_stat[3] && !xfer_end));
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> if_stat[6]);
    p_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat3_rd |=> if_stat[5]);
endmodule

// File: rtl/cdc_dec_track.sv
// Module: status word with read-tracking record and ready-bit re-arm.
// Assumes rd_hit is one-hot (or zero) per performed read and stat_ld
// does not coincide with a status byte 3 read.
module cdc_dec_track
    import cdc_regport_pkg::*;
#(
    parameter logic [NREG-1:0] TRACK_NEED = 16'h73F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NREG-1:0]   rd_hit,
    input  logic              arm,
    input  logic              stat_ld,
    input  logic [QUAD_W-1:0] stat_in,
    output logic [QUAD_W-1:0] stat
);
    localparam logic [QUAD_W-1:0] STAT_RST = 32'h0000_0080;
    localparam logic [BYTE_W-1:0] READY    = 8'h80;

    logic [NREG-1:0] seen;
    logic [NREG-1:0] seen_nx;
    logic            complete;

    // only the decode registers named in TRACK_NEED are recorded
    for (genvar k = 0; k < NREG; k++) begin : g_seen
        assign seen_nx[k] = seen[k] | (rd_hit[k] & TRACK_NEED[k]);
    end

    // record covers every needed register
    always_comb complete = ((seen & TRACK_NEED) == TRACK_NEED);

    // tracking record register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) seen <= '0;
        else                    seen <= seen_nx;
    end

    // status word: decoder load, then re-arm of byte 3
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            stat <= STAT_RST;
        else begin
            if (stat_ld) stat <= stat_in;
            if (rd_hit[NREG-1] && arm && complete)
                stat[QUAD_W-1 -: BYTE_W] <= READY;
        end
    end

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[NREG-1] && arm && complete && !soft_rst) |=> stat[31:24] == 8'h80);
    p_noarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[NREG-1] && !(arm && complete) && !stat_ld && !soft_rst) |=> $stable(stat));
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit));
endmodule

// File: rtl/cdc_regport.sv
// Module: top of the host register port. Decodes the index for the
// read and write maps, holds the plain data registers and the registered
// read data, and wires the index, transfer and status sub-blocks.
// Assumes one access per cycle is intended; collisions resolve as
// load > write > read.
module cdc_regport
    import cdc_regport_pkg::*;
#(
    parameter logic [WORD_W-1:0] WA_RESET   = 16'd4704,
    parameter logic [NREG-1:0]   TRACK_NEED = 16'h73F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_ld,
    input  logic [IDX_W-1:0]  idx_din,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] cmd_in,
    input  logic [POS_W-1:0]  pos_min,
    input  logic [POS_W-1:0]  pos_sec,
    input  logic [POS_W-1:0]  pos_frm,
    input  logic              stat_ld,
    input  logic [QUAD_W-1:0] stat_in,
    input  logic [BYTE_W-1:0] ifstat_clr,
    input  logic              end_set,
    output logic [BYTE_W-1:0] sub_out,
    output logic [BYTE_W-1:0] if_ctrl,
    output logic [BYTE_W-1:0] if_stat,
    output logic [WORD_W-1:0] byte_cnt,
    output logic [WORD_W-1:0] data_addr,
    output logic [WORD_W-1:0] write_addr,
    output logic [WORD_W-1:0] pointer,
    output logic [BYTE_W-1:0] ctrl0,
    output logic [BYTE_W-1:0] ctrl1,
    output logic [BYTE_W-1:0] ctrl2,
    output logic [QUAD_W-1:0] header,
    output logic [QUAD_W-1:0] stat_word,
    output logic              xfer_active,
    output logic              xfer_end
);
    logic              do_wr;
    logic              do_rd;
    logic [NREG-1:0]   wr_hit;
    logic [NREG-1:0]   rd_hit;
    logic              soft_rst;
    logic              cnt_stop;
    logic [BYTE_W-1:0] rd_mux;

    // qualify strobes: load beats write, write beats read
    always_comb begin
        do_wr = wr_stb && !idx_ld;
        do_rd = rd_stb && !wr_stb && !idx_ld;
    end

    // one-hot decode of the index for each map
    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign wr_hit[k] = do_wr && (idx == IDX_W'(k));
        assign rd_hit[k] = do_rd && (idx == IDX_W'(k));
    end

    // soft reset and transfer stop requests
    always_comb begin
        soft_rst = wr_hit[W_SRST];
        cnt_stop = wr_hit[W_IFCTRL] && !wdata[1];
    end

    cdc_idx_ctr u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (idx_ld),
        .din   (idx_din),
        .rd    (do_rd),
        .wr    (do_wr),
        .idx   (idx)
    );

    cdc_hdr_build u_hdr (
        .pos_min (pos_min),
        .pos_sec (pos_sec),
        .pos_frm (pos_frm),
        .sub_hdr (ctrl1[0]),
        .hdr     (header)
    );

    cdc_xfer_ctl u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .clr_mask   (ifstat_clr),
        .end_set    (end_set),
        .ifc_wr     (wr_hit[W_IFCTRL]),
        .ifc_en_bit (wdata[1]),
        .trig_wr    (wr_hit[W_TRIG]),
        .xfer_en    (if_ctrl[1]),
        .ack_wr     (wr_hit[W_ACK]),
        .stat3_rd   (rd_hit[R_STAT3]),
        .if_stat    (if_stat),
        .active     (xfer_active),
        .xfer_end   (xfer_end)
    );

    cdc_dec_track #(.TRACK_NEED(TRACK_NEED)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_hit   (rd_hit),
        .arm      (ctrl0[7] && if_ctrl[5]),
        .stat_ld  (stat_ld),
        .stat_in  (stat_in),
        .stat     (stat_word)
    );

    // write-map data registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sub_out    <= '0;
            if_ctrl    <= '0;
            byte_cnt   <= '0;
            data_addr  <= '0;
            write_addr <= WA_RESET;
            pointer    <= '0;
            ctrl0      <= '0;
            ctrl1      <= '0;
            ctrl2      <= '0;
        end else begin
            if (cnt_stop) byte_cnt <= '0;
            if (do_wr) begin
                case (idx)
                    4'h0: sub_out          <= wdata;
                    4'h1: if_ctrl          <= wdata;
                    4'h2: byte_cnt[7:0]    <= wdata;
                    4'h3: byte_cnt[15:8]   <= wdata;
                    4'h4: data_addr[7:0]   <= wdata;
                    4'h5: data_addr[15:8]  <= wdata;
                    4'h8: write_addr[7:0]  <= wdata;
                    4'h9: write_addr[15:8] <= wdata;
                    4'hA: ctrl0            <= wdata;
                    4'hB: ctrl1            <= wdata;
                    4'hC: pointer[7:0]     <= wdata;
                    4'hD: pointer[15:8]    <= wdata;
                    4'hE: ctrl2            <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // read-map selection
    always_comb begin
        case (idx)
            4'h0: rd_mux = cmd_in;
            4'h1: rd_mux = if_stat;
            4'h2: rd_mux = byte_cnt[7:0];
            4'h3: rd_mux = byte_cnt[15:8];
            4'h4: rd_mux = header[7:0];
            4'h5: rd_mux = header[15:8];
            4'h6: rd_mux = header[23:16];
            4'h7: rd_mux = header[31:24];
            4'h8: rd_mux = pointer[7:0];
            4'h9: rd_mux = pointer[15:8];
            4'hA: rd_mux = write_addr[7:0];
            4'hB: rd_mux = write_addr[15:8];
            4'hC: rd_mux = stat_word[7:0];
            4'hD: rd_mux = stat_word[15:8];
            4'hE: rd_mux = stat_word[23:16];
            default: rd_mux = stat_word[31:24];
        endcase
    end

    // registered read data, updated only by a performed read
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (do_rd) rdata <= rd_mux;
    end

    p_cnt_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_stop |=> byte_cnt == '0);
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(rdata));
    p_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (write_addr == WA_RESET && if_ctrl == '0 && stat_word == 32'h80));
    p_strobe_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ld && (rd_stb || wr_stb)) |=> $stable(rdata));
endmodule

// File: tb/cdc_regport_test.sv
`timescale 1ns/1ps
module cdc_regport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_ld = 1'b0;
    logic [3:0]  idx_din = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  idx;
    logic [7:0]  cmd_in = 8'h5A;
    logic [6:0]  pos_min = '0, pos_sec = '0, pos_frm = '0;
    logic        stat_ld = 1'b0;
    logic [31:0] stat_in = '0;
    logic [7:0]  ifstat_clr = '0;
    logic        end_set = 1'b0;
    logic [7:0]  sub_out, if_ctrl, if_stat, ctrl0, ctrl1, ctrl2;
    logic [15:0] byte_cnt, data_addr, write_addr, pointer;
    logic [31:0] header, stat_word;
    logic        xfer_active, xfer_end;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    cdc_regport uut (
        .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_din(idx_din),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
        .idx(idx), .cmd_in(cmd_in), .pos_min(pos_min), .pos_sec(pos_sec),
        .pos_frm(pos_frm), .stat_ld(stat_ld), .stat_in(stat_in),
        .ifstat_clr(ifstat_clr), .end_set(end_set), .sub_out(sub_out),
        .if_ctrl(if_ctrl), .if_stat(if_stat), .byte_cnt(byte_cnt),
        .data_addr(data_addr), .write_addr(write_addr), .pointer(pointer),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2), .header(header),
        .stat_word(stat_word), .xfer_active(xfer_active), .xfer_end(xfer_end)
    );

    // monitor: a plain read seen at a falling edge has its data ready now
    always @(negedge clk) begin
        if (rd_stb && !wr_stb && !idx_ld) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard underflow: actual %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic op(input logic ld, input logic [3:0] di, input logic rd,
                      input logic wr, input logic [7:0] d);
        @(negedge clk); #1;
        idx_ld = ld; idx_din = di; rd_stb = rd; wr_stb = wr; wdata = d;
        @(negedge clk); #1;
        idx_ld = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        op(1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic wr(input logic [7:0] d);
        op(1'b0, 4'h0, 1'b0, 1'b1, d);
    endtask

    task automatic ld(input logic [3:0] i);
        op(1'b1, i, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        vectors++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", t, act, e);
        end
    endtask

    task automatic pulse_clr(input logic [7:0] m);
        @(negedge clk); #1; ifstat_clr = m;
        @(negedge clk); #1; ifstat_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 idx", idx, 0);
        chk("R1 if_stat", if_stat, 32'hFF);
        chk("R1 write_addr", write_addr, 32'h1260);
        chk("R1 stat_word", stat_word, 32'h80);
        chk("R1 header", header, 32'h01000000);
        chk("R1 active", xfer_active, 0);
        chk("R1 xfer_end", xfer_end, 0);
        chk("R1 rdata", rdata, 0);
        // R2 full read sweep
        rd_exp(8'h5A, "R2 cmd_in");
        rd_exp(8'hFF, "R1 if_stat"); rd_exp(8'h00, "R1 cnt lo"); rd_exp(8'h00, "R1 cnt hi");
        rd_exp(8'h00, "R1 hdr0"); rd_exp(8'h00, "R1 hdr1"); rd_exp(8'h00, "R1 hdr2");
        rd_exp(8'h01, "R1 hdr3"); rd_exp(8'h00, "R1 ptr lo"); rd_exp(8'h00, "R1 ptr hi");
        rd_exp(8'h60, "R1 wa lo"); rd_exp(8'h12, "R1 wa hi"); rd_exp(8'h80, "R1 stat0");
        rd_exp(8'h00, "R1 stat1"); rd_exp(8'h00, "R1 stat2"); rd_exp(8'h00, "R1 stat3");
        chk("R2 idx stays F", idx, 4'hF);
        rd_exp(8'h00, "R2 stat3 again");
        chk("R2 idx still F", idx, 4'hF);
        // R3 writes
        ld(4'h0);
        wr(8'h11); wr(8'h22); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
        chk("R3 sub_out", sub_out, 32'h11);
        chk("R3 if_ctrl", if_ctrl, 32'h22);
        chk("R3 byte_cnt", byte_cnt, 32'h1234);
        chk("R3 data_addr", data_addr, 32'h5678);
        chk("R3 idx at 6", idx, 4'h6);
        // R6 end flag then trigger
        @(negedge clk); #1 end_set = 1'b1;
        @(negedge clk); #1 end_set = 1'b0;
        chk("R6 end_set", xfer_end, 1);
        wr(8'h00);
        chk("R6 active", xfer_active, 1);
        chk("R6 if_stat", if_stat, 32'hF7);
        chk("R6 xfer_end cleared", xfer_end, 0);
        chk("R3 trigger keeps idx", idx, 4'h6);
        // R7 acknowledge
        ld(4'h7);
        pulse_clr(8'h40);
        chk("R7 bit6 cleared by engine", if_stat, 32'hB7);
        wr(8'h00);
        chk("R7 ack", if_stat, 32'hF7);
        chk("R3 ack keeps idx", idx, 4'h7);
        // R3 upper map
        ld(4'h8);
        wr(8'hCD); wr(8'hAB); wr(8'h80); wr(8'h00); wr(8'hEF); wr(8'hBE);
        chk("R3 write_addr", write_addr, 32'hABCD);
        chk("R3 ctrl0", ctrl0, 32'h80);
        chk("R3 pointer", pointer, 32'hBEEF);
        chk("R3 idx at E", idx, 4'hE);
        wr(8'h99);
        chk("R3 ctrl2", ctrl2, 32'h99);
        chk("R3 ctrl2 keeps idx", idx, 4'hE);
        // R2 read back
        ld(4'h2); rd_exp(8'h34, "R2 cnt lo"); rd_exp(8'h12, "R2 cnt hi");
        ld(4'h8); rd_exp(8'hEF, "R2 ptr lo"); rd_exp(8'hBE, "R2 ptr hi");
        rd_exp(8'hCD, "R2 wa lo"); rd_exp(8'hAB, "R2 wa hi");
        // R5 stop
        ld(4'h1); wr(8'h20);
        chk("R5 byte_cnt", byte_cnt, 0);
        chk("R5 active", xfer_active, 0);
        chk("R5 if_stat", if_stat, 32'hFF);
        chk("R3 if_ctrl idx", idx, 4'h2);
        // R6 trigger disabled
        ld(4'h6); wr(8'h00);
        chk("R6 no start active", xfer_active, 0);
        chk("R6 no start if_stat", if_stat, 32'hFF);
        // R4 header
        pos_min = 7'd12; pos_sec = 7'd34; pos_frm = 7'd56;
        #1 chk("R4 header bcd", header, 32'h01563412);
        ld(4'h4);
        rd_exp(8'h12, "R4 min"); rd_exp(8'h34, "R4 sec");
        rd_exp(8'h56, "R4 frm"); rd_exp(8'h01, "R4 mode");
        ld(4'hB); wr(8'h01);
        chk("R4 header zero", header, 0);
        ld(4'h4);
        rd_exp(8'h00, "R4 sub0"); rd_exp(8'h00, "R4 sub1");
        rd_exp(8'h00, "R4 sub2"); rd_exp(8'h00, "R4 sub3");
        ld(4'hB); wr(8'h00);
        // R11 priority
        ld(4'h0); rd_exp(8'h5A, "R11 prep");
        op(1'b1, 4'h3, 1'b1, 1'b0, 8'h00);
        chk("R11 load wins idx", idx, 4'h3);
        chk("R11 load wins rdata", rdata, 32'h5A);
        op(1'b0, 4'h0, 1'b1, 1'b1, 8'h44);
        chk("R11 write wins cnt", byte_cnt, 32'h4400);
        chk("R11 write wins idx", idx, 4'h4);
        chk("R12 rdata held", rdata, 32'h5A);
        // R10 soft reset
        ld(4'hF); wr(8'h00);
        chk("R10 if_ctrl", if_ctrl, 0);
        chk("R10 byte_cnt", byte_cnt, 0);
        chk("R10 data_addr", data_addr, 0);
        chk("R10 write_addr", write_addr, 32'h1260);
        chk("R10 ctrl0", ctrl0, 0);
        chk("R10 ctrl2", ctrl2, 0);
        chk("R10 pointer", pointer, 0);
        chk("R10 sub_out", sub_out, 0);
        chk("R10 if_stat", if_stat, 32'hFF);
        chk("R10 stat_word", stat_word, 32'h80);
        chk("R10 idx kept", idx, 4'hF);
        // R9 re-arm
        @(negedge clk); #1 stat_ld = 1'b1; stat_in = 32'h11223344;
        @(negedge clk); #1 stat_ld = 1'b0;
        chk("R9 stat loaded", stat_word, 32'h11223344);
        ld(4'h1); wr(8'h22);
        ld(4'hA); wr(8'h80);
        pulse_clr(8'h20);
        chk("R8 bit5 cleared", if_stat, 32'hDF);
        ld(4'h1); rd_exp(8'hDF, "R8 if_stat before");
        ld(4'hF); rd_exp(8'h11, "R8 old stat3");
        chk("R8 bit5 set", if_stat, 32'hFF);
        rd_exp(8'h11, "R9 partial record no rearm");
        ld(4'h4);
        rd_exp(8'h12, "R9 h0"); rd_exp(8'h34, "R9 h1"); rd_exp(8'h56, "R9 h2");
        rd_exp(8'h01, "R9 h3"); rd_exp(8'h00, "R9 p0"); rd_exp(8'h00, "R9 p1");
        ld(4'hC);
        rd_exp(8'h44, "R2 stat0"); rd_exp(8'h33, "R2 stat1"); rd_exp(8'h22, "R2 stat2");
        rd_exp(8'h11, "R9 old value returned");
        rd_exp(8'h80, "R9 rearmed");
        chk("R9 stat_word", stat_word, 32'h80223344);
        repeat (3) @(negedge clk);
        chk("R12 rdata idle", rdata, 32'h80);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule